// File: doc/BRIEF.md
# SPI Burst Register Access Port

This block is the host-facing front end of a two-channel serial bus controller. A host reaches a bank of 5-bit-addressed byte registers through an SPI slave link (SCLK, MOSI, MISO, active-low chip select). Each chip-select window opens with a command byte that selects read or write and loads a register pointer. Every further byte in the same window accesses the register under the pointer and then advances it. One clock drives the whole block. The SPI pins are brought into that clock through synchronizers and edge detectors, so SCLK must run well below the system clock.

On every data byte the block writes and reads back in the same exchange: the old contents of the addressed register leave on MISO while the new MOSI byte arrives. The data registers face per-channel FIFOs that sit outside the block. Reads show the head of each receive FIFO. Any data-byte access to a channel's low register pops that FIFO. A write to a channel's low register pushes the full high:low word into that channel's transmit FIFO. A status byte is captured when chip select falls. In short-word mode the pointer steps over the channel's high register.

Top module: `spi_burst_port`

## Requirements
- R1: SPI mode 0: MOSI is sampled on the SCLK rising edge and MISO changes on the falling edge, most significant bit first. In the first byte after CS falls, bit 7 = 1 selects write and 0 selects read, bits 6 and 5 are ignored, and bits 4..0 load the pointer.
- R2: Each later byte in the same CS window accesses the register at the pointer, and the pointer then advances to the next address.
- R3: Advancing from address 21 (or from any address above it) gives address 0.
- R4: During the command byte, MISO carries the register at the pointer as the previous transaction left it.
- R5: During a data byte, MISO carries the old contents of the addressed register. In write mode the MOSI byte then replaces them. In read mode the register is not changed.
- R6: Address map. 0 and 2 are the high data registers of channels 0 and 1, and 1 and 3 are their low data registers. A read of a high or low data register returns bits 15..8 or 7..0 of that channel's receive head. 4 is status, 5 and 6 are control for channels 0 and 1 (bit 0 = short-word mode), and 7..21 are plain read/write storage. Addresses 22..31 read as 0 and ignore writes.
- R7: The status byte is captured from the status input when CS falls. It does not change again until the next CS fall.
- R8: A data byte at address 1 or 3 gives a one-cycle receive pop strobe for channel 0 or 1, in read mode and in write mode. Command bytes and accesses to other addresses pop nothing.
- R9: When a channel's short-word bit is set, a sequential advance that would land on that channel's high register (0 or 2) goes on to the next address.
- R10: A CS rise in the middle of a byte discards the partial byte: no register write, no pointer change, no strobe.
- R11: A write to a channel's low register gives a one-cycle transmit push strobe in the same cycle as its pop strobe. The pushed word is {last byte written to that channel's high register, new low byte}.
- R12: MISO is 0 while CS is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock |
| mosi | input | 1 | SPI data from host |
| cs_n | input | 1 | SPI chip select, active low |
| miso | output | 1 | SPI data to host |
| status_i | input | 8 | Live status flags, captured at CS fall |
| rx_head_i | input | 2x16 | Head word of each channel's receive FIFO |
| rx_pop_o | output | 2 | Receive FIFO pop strobes, one per channel |
| tx_push_o | output | 2 | Transmit FIFO push strobes, one per channel |
| tx_word_o | output | 2x16 | Word to push into each transmit FIFO |

## Verification
A data-byte write to a channel's low register pops that channel's receive FIFO and pushes its transmit FIFO in the same system clock cycle. The bench provokes this with writes to address 1 and address 3, reached both directly and through a short-word skip. It counts the cycles in which both strobes are high together and compares the captured push word with the high byte written earlier. A second collision is a status capture against writes made earlier in the same burst. The bench changes the status input in mid-window and expects the value captured at CS fall, then the new value after the next CS fall.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 8;
  localparam int NCH       = 2;
  localparam int WORD_W    = 2 * DATA_W;
  localparam int LAST_ADDR = 21;
  localparam int STAT_ADDR = 2 * NCH;
  localparam int CTRL_BASE = STAT_ADDR + 1;
  localparam int SCR_BASE  = CTRL_BASE + NCH;
  localparam int SCR_N     = LAST_ADDR - SCR_BASE + 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  function automatic addr_t hi_addr(input int ch);
    return addr_t'(2 * ch);
  endfunction

  function automatic addr_t lo_addr(input int ch);
    return addr_t'(2 * ch + 1);
  endfunction

  // Sequential pointer advance: wrap past the top, skip short-mode high regs.
  function automatic addr_t next_addr(input addr_t cur, input logic [NCH-1:0] short_mode);
    addr_t n;
    n = (int'(cur) >= LAST_ADDR) ? '0 : cur + addr_t'(1);
    for (int c = 0; c < NCH; c++) begin
      if (short_mode[c] && n == hi_addr(c)) n = n + addr_t'(1);
    end
    return n;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){INIT[b]}};
      else        chain <= {chain[STAGES-1:0], d[b]};
    end
    assign q[b]    = chain[STAGES-1];
    assign rise[b] = chain[STAGES-1] & ~chain[STAGES];
    assign fall[b] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_act,
  input  logic  sclk_rise,
  input  logic  sclk_fall,
  input  logic  mosi_s,
  input  logic  load,
  input  byte_t load_byte,
  output logic  byte_done,
  output byte_t rx_byte,
  output logic  miso_bit
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0] bit_cnt;
  byte_t            rx_sh;
  byte_t            tx_sh;

  // R1: capture on rising SCLK; byte boundary after DATA_W bits.
  // R10: leaving the CS window clears the partial byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sclk_rise) begin
        rx_sh <= {rx_sh[DATA_W-2:0], mosi_s};
        if (bit_cnt == CNT_W'(DATA_W - 1)) begin
          bit_cnt   <= '0;
          rx_byte   <= {rx_sh[DATA_W-2:0], mosi_s};
          byte_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end
    end
  end

  // R1: shift out on falling SCLK, except on the falling edge at a byte boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         tx_sh <= '0;
    else if (load)                      tx_sh <= load_byte;
    else if (sclk_fall && bit_cnt != '0) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
  end

  // R12: quiet line outside the window.
  assign miso_bit = cs_act & tx_sh[DATA_W-1];

  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0 && !byte_done));
  assert_done_after_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(sclk_rise));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_burst_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  snap,
  input  byte_t                 status_i,
  input  logic [NCH-1:0][WORD_W-1:0] rx_head_i,
  input  logic                  wr_en,
  input  addr_t                 wr_addr,
  input  byte_t                 wr_data,
  input  addr_t                 rd_addr,
  output byte_t                 rd_data,
  output logic [NCH-1:0]        short_mode,
  output logic [NCH-1:0]        tx_push,
  output logic [NCH-1:0][WORD_W-1:0] tx_word
);
  byte_t snap_q;
  byte_t hold_q [NCH];
  byte_t ctrl_q [NCH];
  byte_t scr_q  [SCR_N];

  // R7: status captured only at the start of a window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (snap) snap_q <= status_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[c] <= '0;
        ctrl_q[c] <= '0;
      end else if (wr_en) begin
        if (wr_addr == hi_addr(c))               hold_q[c] <= wr_data;
        if (wr_addr == addr_t'(CTRL_BASE + c))   ctrl_q[c] <= wr_data;
      end
    end
    assign short_mode[c] = ctrl_q[c][0];
    // R11: low-register write pushes the assembled word.
    assign tx_push[c] = wr_en && (wr_addr == lo_addr(c));
    assign tx_word[c] = {hold_q[c], wr_data};
  end

  for (genvar i = 0; i < SCR_N; i++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        scr_q[i] <= '0;
      else if (wr_en && wr_addr == addr_t'(SCR_BASE + i)) scr_q[i] <= wr_data;
    end
  end

  // R6: read map; unmapped addresses return zero.
  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == hi_addr(c))             rd_data = rx_head_i[c][WORD_W-1:DATA_W];
      if (rd_addr == lo_addr(c))             rd_data = rx_head_i[c][DATA_W-1:0];
      if (rd_addr == addr_t'(CTRL_BASE + c)) rd_data = ctrl_q[c];
    end
    if (rd_addr == addr_t'(STAT_ADDR)) rd_data = snap_q;
    for (int i = 0; i < SCR_N; i++) begin
      if (rd_addr == addr_t'(SCR_BASE + i)) rd_data = scr_q[i];
    end
  end

  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(snap_q));
endmodule

// File: rtl/spi_burst_port.sv
module spi_burst_port
  import spi_burst_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  mosi,
  input  logic                  cs_n,
  output logic                  miso,
  input  logic [7:0]            status_i,
  input  logic [1:0][15:0]      rx_head_i,
  output logic [1:0]            rx_pop_o,
  output logic [1:0]            tx_push_o,
  output logic [1:0][15:0]      tx_word_o
);
  logic [2:0] pin_q, pin_rise, pin_fall;
  logic       cs_act, cs_fall_evt, sclk_rise, sclk_fall, mosi_s;

  spi_pin_sync #(.W(3), .STAGES(2), .INIT(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, mosi, sclk}),
    .q(pin_q), .rise(pin_rise), .fall(pin_fall)
  );

  assign cs_act      = ~pin_q[2];
  assign cs_fall_evt = pin_fall[2];
  assign mosi_s      = pin_q[1];
  assign sclk_rise   = pin_rise[0];
  assign sclk_fall   = pin_fall[0];

  logic  byte_done, reload, in_cmd, wr_mode;
  byte_t rx_byte, rd_data;
  addr_t ptr;
  logic  [NCH-1:0] short_mode;

  spi_byte_engine u_eng (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .load(reload), .load_byte(rd_data),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso_bit(miso)
  );

  // Named events for assertions.
  logic cmd_evt, data_evt, data_wr;
  assign cmd_evt  = byte_done &  in_cmd;
  assign data_evt = byte_done & ~in_cmd;
  assign data_wr  = data_evt & wr_mode;

  // R1, R2, R3, R9: command decode and pointer advance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      in_cmd  <= 1'b0;
      wr_mode <= 1'b0;
      reload  <= 1'b0;
    end else begin
      reload <= cs_fall_evt | byte_done;
      if (cs_fall_evt) in_cmd <= 1'b1;
      else if (cmd_evt) begin
        in_cmd  <= 1'b0;
        wr_mode <= rx_byte[DATA_W-1];
        ptr     <= rx_byte[ADDR_W-1:0];
      end else if (data_evt) begin
        ptr <= next_addr(ptr, short_mode);
      end
    end
  end

  spi_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .snap(cs_fall_evt), .status_i(status_i),
    .rx_head_i(rx_head_i), .wr_en(data_wr), .wr_addr(ptr), .wr_data(rx_byte),
    .rd_addr(ptr), .rd_data(rd_data), .short_mode(short_mode),
    .tx_push(tx_push_o), .tx_word(tx_word_o)
  );

  // R8: pop on any data-byte access to a channel low register.
  for (genvar c = 0; c < NCH; c++) begin : g_pop
    assign rx_pop_o[c] = data_evt && (ptr == lo_addr(c));
    assert_push_with_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push_o[c] |-> rx_pop_o[c]);
  end

  assert_pop_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_pop_o));
  assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt && ptr == addr_t'(LAST_ADDR) && !short_mode[0]) |=> ptr == '0);
  assert_skip_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_evt && ptr == addr_t'(1) && short_mode[1]) |=> ptr == addr_t'(3));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> !miso);
endmodule

// File: tb/spi_burst_port_bench.sv
module spi_burst_port_bench;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso;
  logic [7:0] status_i = 8'h00;
  logic [1:0][15:0] rx_head_i;
  logic [1:0] rx_pop_o, tx_push_o;
  logic [1:0][15:0] tx_word_o;

  always #2.5 clk = ~clk;

  assign rx_head_i[0] = 16'hA1B2;
  assign rx_head_i[1] = 16'hC3D4;

  spi_burst_port u_spi_burst_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso),
    .status_i(status_i), .rx_head_i(rx_head_i), .rx_pop_o(rx_pop_o),
    .tx_push_o(tx_push_o), .tx_word_o(tx_word_o)
  );

  int n_chk = 0, n_bad = 0;
  int pop_cnt [2] = '{0, 0};
  int push_cnt [2] = '{0, 0};
  int both_cnt [2] = '{0, 0};
  logic [15:0] last_word [2];

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (rx_pop_o[c]) pop_cnt[c] <= pop_cnt[c] + 1;
      if (tx_push_o[c]) begin
        push_cnt[c] <= push_cnt[c] + 1;
        last_word[c] <= tx_word_o[c];
      end
      if (tx_push_o[c] && rx_pop_o[c]) both_cnt[c] <= both_cnt[c] + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_open();
    cs_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic cs_close();
    wclk(HALF / 2);
    cs_n = 1'b1;
    wclk(2 * HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wclk(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
  endtask

  // cmd, data, expected MISO during cmd, expected MISO during data
  localparam logic [31:0] VEC [8] = '{
    {8'h87, 8'h11, 8'hA1, 8'h00},
    {8'h88, 8'h22, 8'h00, 8'h00},
    {8'h67, 8'hFF, 8'h00, 8'h11},
    {8'h07, 8'h00, 8'h22, 8'h11},
    {8'hE8, 8'h33, 8'h22, 8'h22},
    {8'h08, 8'h00, 8'h00, 8'h33},
    {8'h95, 8'h5A, 8'h00, 8'h00},
    {8'h15, 8'h00, 8'hA1, 8'h5A}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] r;
    wclk(4);
    rst_n = 1'b1;
    wclk(4);
    // R12: reset state, idle line and no strobes
    check("R12 idle miso", {31'd0, miso}, 32'd0);
    check("R8 reset pops", pop_cnt[0] + pop_cnt[1], 0);
    check("R11 reset pushes", push_cnt[0] + push_cnt[1], 0);

    // R1 R4 R5: single-byte transactions on storage registers
    for (int v = 0; v < 8; v++) begin
      cs_open();
      xfer(VEC[v][31:24], r);
      check("R4 cmd-byte miso", r, VEC[v][15:8]);
      xfer(VEC[v][23:16], r);
      check("R5 data-byte readback", r, VEC[v][7:0]);
      cs_close();
    end

    // R2 R3: burst across the top address into channel 0 high
    cs_open();
    xfer(8'h94, r); check("R4 cmd miso reg0", r, 8'hA1);
    xfer(8'h44, r); check("R2 addr20 old", r, 8'h00);
    xfer(8'h55, r); check("R2 addr21 old", r, 8'h5A);
    xfer(8'h66, r); check("R3 wrapped to addr0", r, 8'hA1);
    cs_close();
    check("R8 no pop on high reg", pop_cnt[0], 0);

    // R11 R8: low write pushes and pops in the same cycle
    cs_open();
    xfer(8'h81, r); check("R3 pointer now 1", r, 8'hB2);
    check("R8 no pop on cmd byte", pop_cnt[0], 0);
    xfer(8'h77, r); check("R6 low reg read", r, 8'hB2);
    cs_close();
    check("R11 push count", push_cnt[0], 1);
    check("R11 pushed word", last_word[0], 16'h6677);
    check("R8 pop count", pop_cnt[0], 1);
    check("R11 push with pop", both_cnt[0], 1);

    // R7: status captured at CS fall, later changes not seen
    status_i = 8'h5C;
    cs_open();
    status_i = 8'h3F;
    xfer(8'h03, r); check("R4 cmd miso reg2", r, 8'hC3);
    xfer(8'h00, r); check("R6 ch1 low read", r, 8'hD4);
    xfer(8'h00, r); check("R7 snapshot value", r, 8'h5C);
    cs_close();
    check("R8 read pop ch1", pop_cnt[1], 1);
    check("R11 read no push", push_cnt[1], 0);
    cs_open();
    xfer(8'h04, r); check("R4 cmd miso ctrl0", r, 8'h00);
    xfer(8'h00, r); check("R7 new snapshot", r, 8'h3F);
    cs_close();
    check("R8 status read no pop", pop_cnt[0] + pop_cnt[1], 2);

    // R9: short-word skip on both channels
    cs_open();
    xfer(8'h85, r);
    xfer(8'h01, r); check("R6 ctrl0 old", r, 8'h00);
    xfer(8'h01, r); check("R6 ctrl1 old", r, 8'h00);
    cs_close();
    cs_open();
    xfer(8'h95, r); check("R4 cmd miso reg7", r, 8'h11);
    xfer(8'h99, r); check("R5 addr21 old", r, 8'h55);
    xfer(8'h42, r); check("R9 skip to addr1", r, 8'hB2);
    xfer(8'h24, r); check("R9 skip to addr3", r, 8'hD4);
    cs_close();
    check("R11 ch0 push count", push_cnt[0], 2);
    check("R11 ch0 word", last_word[0], 16'h6642);
    check("R11 ch1 word", last_word[1], 16'h0024);
    check("R11 ch1 same cycle", both_cnt[1], 1);

    // R10: partial byte discarded
    cs_open();
    xfer(8'h87, r); check("R4 cmd miso status", r, 8'h3F);
    for (int i = 0; i < 4; i++) begin
      mosi = 1'b1;
      wclk(HALF);
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
    cs_close();
    cs_open();
    xfer(8'h07, r); check("R10 pointer unmoved", r, 8'h11);
    xfer(8'h00, r); check("R10 reg7 unwritten", r, 8'h11);
    cs_close();
    check("R12 idle after", {31'd0, miso}, 32'd0);
    check("R10 no stray push", push_cnt[0] + push_cnt[1], 3);
    summary();
  end
endmodule